// File: doc/BRIEF.md
# Exception entry and interrupt-enable controller

This block sits beside the decode stage of a small in-order processor and owns the interrupt-enable state. The pipeline hands it one decoded control operation per cycle: a trap, an unsigned divide, or a jump through a register. It also hands it at most one control-register access per cycle.

From these inputs the controller keeps a three-bit enable register. The register holds a live global enable bit and two saved copies of that bit: one saved on ordinary exception entry and one saved on breakpoint entry. Each return path restores the live bit from its own saved copy.

On an exception the controller asks the register file to save the faulting PC into register 30 (exceptions) or register 31 (breakpoints). It then sends fetch to a vector computed from a base register. Software writes to the enable, mask or pending registers force a refetch of the next instruction, so the new state applies before that instruction runs. All results appear one clock after the inputs that caused them.

Top module: `exc_ctl_unit`

## Requirements
- R1: A trap (op_kind 0) decodes op_imm as follows: 7 is a system call (exception code 7), 2 is a break (exception code 1), and every other value pulses illegal_op. An illegal trap leaves the enable register unchanged, and it produces no redirect, no register save and no exception.
- R2: On system-call entry the enable register, with bit 0 the live enable, bit 1 the exception copy and bit 2 the breakpoint copy, changes as follows: bit 1 takes the old bit 0, bit 0 clears, and bit 2 is kept. save_we writes op_pc to register 30.
- R3: On break entry, bit 2 takes the old bit 0, bit 0 clears, and bit 1 is kept. save_we writes op_pc to register 31.
- R4: A jump (op_kind 2) redirects to op_target. Through register 30 it sets bit 0 to the old bit 1. Through any register other than 30 or 31 it leaves the enable register unchanged. Bits 1 and 2 never change on a jump.
- R5: A jump through register 31 sets bit 0 to the old bit 2 and redirects to op_target.
- R6: A divide (op_kind 1) with op_divisor_zero set enters exception code 5. It updates the enable register as a system call does, and it writes the divide's op_pc to register 30. A divide with a nonzero divisor has no effect.
- R7: On every exception entry the redirect target is the base register with its low 8 bits replaced by 32 times the exception code. exc_valid and exc_code report the entry.
- R8: A legal software write to index 0 loads csr_wdata[2:0] into the enable register. A write to index 0, 1 (mask) or 2 (pending) redirects to csr_pc+4.
- R9: A write to index 3 loads the whole word into the base register with no redirect. A read of index 0 returns the enable register zero-extended. A read of index 3 returns the base. A legal read of index 1, 2, 4 or 5 returns 0.
- R10: csr_err pulses, and no state changes, on any of these accesses: a write to index 4 (cycle) or 5 (config); a read of index 6 to 15 (the two cache-control registers, then four breakpoint and four watchpoint registers); any access to index 16 to 31.
- R11: When a jump or an exception entry shares a cycle with a software write, the write is dropped. The operation's enable update and redirect are applied, and the dropped write raises no error.
- R12: After reset the enable register is 0, the base is RESET_BASE, and every pulse output is 0. Each pulse output is valid for exactly the one cycle after its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A control operation is presented |
| op_kind | input | 2 | 0 trap, 1 unsigned divide/remainder, 2 register jump, 3 none |
| op_pc | input | XLEN | PC of the operation |
| op_imm | input | 5 | Trap kind immediate |
| op_reg | input | 5 | Register index a jump goes through |
| op_divisor_zero | input | 1 | Divide operand is zero |
| op_target | input | XLEN | Jump destination (register value) |
| csr_we | input | 1 | Software register write |
| csr_re | input | 1 | Software register read |
| csr_idx | input | 5 | Register index of the access |
| csr_wdata | input | XLEN | Write data |
| csr_pc | input | XLEN | PC of the access instruction |
| ie_bits | output | 3 | Enable register {breakpoint copy, exception copy, live} |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | XLEN | Redirect destination |
| save_we | output | 1 | Register-file write of the faulting PC |
| save_reg | output | 5 | 30 or 31 |
| save_data | output | XLEN | Faulting PC |
| exc_valid | output | 1 | Exception entry pulse |
| exc_code | output | 3 | Exception number |
| illegal_op | output | 1 | Illegal trap immediate pulse |
| csr_rd_data | output | XLEN | Read data |
| csr_err | output | 1 | Access error pulse |

## Verification
The bench builds the block with XLEN of 16 and the reset base at 0x1200. At that width every PC, target and vector is easy to predict as a short hex value.

The bench sweeps all 32 trap immediates and all 32 jump registers against each of the 8 enable-register values. It also sweeps both divisor cases against each enable value, and all 32 register indices for both reads and writes. Every save/restore combination and every legality class is therefore checked. Base rewrites and collisions between operations and writes cover the vector arithmetic and the priority rule.

// File: rtl/exc_ctl_pkg.sv
// Shared constants and types of the exception/enable controller.
// Assumes one decoded operation per cycle from the pipeline.
package exc_ctl_pkg;

    typedef enum logic [1:0] {
        OPK_TRAP = 2'd0,
        OPK_DIV  = 2'd1,
        OPK_JUMP = 2'd2,
        OPK_NONE = 2'd3
    } op_kind_e;

    localparam logic [4:0] TRAP_IMM_SCALL = 5'd7;
    localparam logic [4:0] TRAP_IMM_BREAK = 5'd2;
    localparam logic [4:0] REG_EXC_LINK   = 5'd30;
    localparam logic [4:0] REG_BRK_LINK   = 5'd31;

    localparam int EXC_CODE_W = 3;
    localparam int VEC_SHIFT  = 5;
    localparam int BASE_LSB   = EXC_CODE_W + VEC_SHIFT;

    localparam logic [EXC_CODE_W-1:0] EXC_BREAK = 3'd1;
    localparam logic [EXC_CODE_W-1:0] EXC_DIVZ  = 3'd5;
    localparam logic [EXC_CODE_W-1:0] EXC_SCALL = 3'd7;

    localparam int EN_W   = 3;
    localparam int EN_IE  = 0;
    localparam int EN_EIE = 1;
    localparam int EN_BIE = 2;

    localparam logic [4:0] CSR_ENABLE  = 5'd0;
    localparam logic [4:0] CSR_MASK    = 5'd1;
    localparam logic [4:0] CSR_PENDING = 5'd2;
    localparam logic [4:0] CSR_BASE    = 5'd3;
    localparam logic [4:0] CSR_CONFIG  = 5'd5;
    localparam logic [4:0] CSR_ICACHE  = 5'd6;
    localparam logic [4:0] CSR_LAST_WO = 5'd15;

    typedef struct packed {
        logic                  entry;
        logic                  to_brk;
        logic [EXC_CODE_W-1:0] code;
        logic                  illegal;
        logic                  jump;
        logic                  ret_exc;
        logic                  ret_brk;
    } trap_act_t;

endpackage

// File: rtl/exc_trap_decode.sv
// Classifies the presented control operation into an action bundle.
// Purely combinational; assumes op_* fields are stable while op_valid is high.
module exc_trap_decode
    import exc_ctl_pkg::*;
(
    input  logic       op_valid,
    input  logic [1:0] op_kind,
    input  logic [4:0] op_imm,
    input  logic [4:0] op_reg,
    input  logic       op_divisor_zero,
    output trap_act_t  act
);

    // Decode kind, trap immediate and jump register into one action.
    always_comb begin
        act = '0;
        if (op_valid) begin
            unique case (op_kind_e'(op_kind))
                OPK_TRAP: begin
                    if (op_imm == TRAP_IMM_SCALL) begin
                        act.entry = 1'b1;
                        act.code  = EXC_SCALL;
                    end else if (op_imm == TRAP_IMM_BREAK) begin
                        act.entry  = 1'b1;
                        act.to_brk = 1'b1;
                        act.code   = EXC_BREAK;
                    end else begin
                        act.illegal = 1'b1;
                    end
                end
                OPK_DIV: begin
                    if (op_divisor_zero) begin
                        act.entry = 1'b1;
                        act.code  = EXC_DIVZ;
                    end
                end
                OPK_JUMP: begin
                    act.jump    = 1'b1;
                    act.ret_exc = (op_reg == REG_EXC_LINK);
                    act.ret_brk = (op_reg == REG_BRK_LINK);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/exc_enable_reg.sv
// Holds the enable register {breakpoint copy, exception copy, live enable}.
// Priority: entry, then return, then software write (already gated upstream).
module exc_enable_reg
    import exc_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  trap_act_t       act,
    input  logic            sw_we,
    input  logic [EN_W-1:0] sw_val,
    output logic [EN_W-1:0] en_q
);

    // Update the live bit and the saved copies by operation priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (act.entry) begin
            en_q[EN_IE] <= 1'b0;
            if (act.to_brk) begin
                en_q[EN_BIE] <= en_q[EN_IE];
            end else begin
                en_q[EN_EIE] <= en_q[EN_IE];
            end
        end else if (act.ret_exc) begin
            en_q[EN_IE] <= en_q[EN_EIE];
        end else if (act.ret_brk) begin
            en_q[EN_IE] <= en_q[EN_BIE];
        end else if (sw_we && !act.jump) begin
            en_q <= sw_val;
        end
    end

endmodule

// File: rtl/exc_csr_port.sv
// Software access port: legality check, base register, registered read data.
// Assumes block_wr is high when a same-cycle operation overrides the write.
module exc_csr_port
    import exc_ctl_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] RESET_BASE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic            csr_re,
    input  logic [4:0]      csr_idx,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            block_wr,
    input  logic [EN_W-1:0] en_q,
    output logic            en_we,
    output logic            refetch,
    output logic [XLEN-1:0] base_q,
    output logic [XLEN-1:0] rd_data,
    output logic            err
);

    localparam int PAD_W = XLEN - EN_W;

    logic wr_go;
    logic wr_legal;
    logic rd_legal;
    logic [XLEN-1:0] rd_mux;

    // Classify the index for each access direction.
    always_comb begin
        rd_legal = (csr_idx <= CSR_CONFIG);
        wr_legal = (csr_idx <= CSR_BASE) ||
                   ((csr_idx >= CSR_ICACHE) && (csr_idx <= CSR_LAST_WO));
        wr_go    = csr_we && !block_wr;
        en_we    = wr_go && (csr_idx == CSR_ENABLE);
        refetch  = wr_go && ((csr_idx == CSR_ENABLE) || (csr_idx == CSR_MASK) ||
                             (csr_idx == CSR_PENDING));
    end

    // Select read data for the registers held locally.
    always_comb begin
        unique case (csr_idx)
            CSR_ENABLE: rd_mux = {{PAD_W{1'b0}}, en_q};
            CSR_BASE:   rd_mux = base_q;
            default:    rd_mux = '0;
        endcase
    end

    // Hold the vector base register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= RESET_BASE;
        end else if (wr_go && (csr_idx == CSR_BASE)) begin
            base_q <= csr_wdata;
        end
    end

    // Register read data and the access-error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            err     <= 1'b0;
        end else begin
            rd_data <= (csr_re && rd_legal) ? rd_mux : '0;
            err     <= (wr_go && !wr_legal) || (csr_re && !rd_legal);
        end
    end

endmodule

// File: rtl/exc_ctl_unit.sv
// Top of the exception entry / interrupt-enable controller.
// Produces redirect, link-register save and exception report one cycle
// after the causing inputs; assumes XLEN is wider than the vector field.
module exc_ctl_unit
    import exc_ctl_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] RESET_BASE = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [1:0]            op_kind,
    input  logic [XLEN-1:0]       op_pc,
    input  logic [4:0]            op_imm,
    input  logic [4:0]            op_reg,
    input  logic                  op_divisor_zero,
    input  logic [XLEN-1:0]       op_target,
    input  logic                  csr_we,
    input  logic                  csr_re,
    input  logic [4:0]            csr_idx,
    input  logic [XLEN-1:0]       csr_wdata,
    input  logic [XLEN-1:0]       csr_pc,
    output logic [2:0]            ie_bits,
    output logic                  redirect_valid,
    output logic [XLEN-1:0]       redirect_pc,
    output logic                  save_we,
    output logic [4:0]            save_reg,
    output logic [XLEN-1:0]       save_data,
    output logic                  exc_valid,
    output logic [EXC_CODE_W-1:0] exc_code,
    output logic                  illegal_op,
    output logic [XLEN-1:0]       csr_rd_data,
    output logic                  csr_err
);

    localparam logic [XLEN-1:0] FETCH_STEP = XLEN'(4);

    trap_act_t       act;
    logic            block_wr;
    logic            en_we;
    logic            refetch;
    logic [XLEN-1:0] base_q;
    logic [XLEN-1:0] vector_pc;
    logic [XLEN-1:0] redir_d;
    logic            redir_go;

    exc_trap_decode u_decode (
        .op_valid        (op_valid),
        .op_kind         (op_kind),
        .op_imm          (op_imm),
        .op_reg          (op_reg),
        .op_divisor_zero (op_divisor_zero),
        .act             (act)
    );

    assign block_wr = act.entry || act.jump;

    exc_csr_port #(
        .XLEN       (XLEN),
        .RESET_BASE (RESET_BASE)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_re    (csr_re),
        .csr_idx   (csr_idx),
        .csr_wdata (csr_wdata),
        .block_wr  (block_wr),
        .en_q      (ie_bits),
        .en_we     (en_we),
        .refetch   (refetch),
        .base_q    (base_q),
        .rd_data   (csr_rd_data),
        .err       (csr_err)
    );

    exc_enable_reg u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .sw_we  (en_we),
        .sw_val (csr_wdata[EN_W-1:0]),
        .en_q   (ie_bits)
    );

    // Pick the redirect source: vector, jump target or refetch.
    always_comb begin
        vector_pc = {base_q[XLEN-1:BASE_LSB], act.code, {VEC_SHIFT{1'b0}}};
        redir_go  = act.entry || act.jump || refetch;
        if (act.entry) begin
            redir_d = vector_pc;
        end else if (act.jump) begin
            redir_d = op_target;
        end else begin
            redir_d = csr_pc + FETCH_STEP;
        end
    end

    // Register the redirect, link save and exception report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            save_we        <= 1'b0;
            save_reg       <= '0;
            save_data      <= '0;
            exc_valid      <= 1'b0;
            exc_code       <= '0;
            illegal_op     <= 1'b0;
        end else begin
            redirect_valid <= redir_go;
            redirect_pc    <= redir_go ? redir_d : '0;
            save_we        <= act.entry;
            save_reg       <= act.entry ? (act.to_brk ? REG_BRK_LINK : REG_EXC_LINK) : '0;
            save_data      <= act.entry ? op_pc : '0;
            exc_valid      <= act.entry;
            exc_code       <= act.code;
            illegal_op     <= act.illegal;
        end
    end

endmodule

// File: rtl/exc_ctl_checker.sv
// Property checker for exc_ctl_unit, attached by bind below.
module exc_ctl_checker
    import exc_ctl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  op_valid,
    input logic [1:0]            op_kind,
    input logic [4:0]            op_imm,
    input logic [4:0]            op_reg,
    input logic                  op_divisor_zero,
    input logic [XLEN-1:0]       op_pc,
    input logic [XLEN-1:0]       op_target,
    input logic                  csr_we,
    input logic [2:0]            ie_bits,
    input logic                  redirect_valid,
    input logic [XLEN-1:0]       redirect_pc,
    input logic                  save_we,
    input logic [4:0]            save_reg,
    input logic [XLEN-1:0]       save_data,
    input logic                  exc_valid,
    input logic [EXC_CODE_W-1:0] exc_code,
    input logic                  illegal_op,
    input logic                  csr_err
);

    AST_ILLEGAL_TRAP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd0 && op_imm != 5'd7 && op_imm != 5'd2 && !csr_we)
        |=> (illegal_op && !redirect_valid && !save_we && $stable(ie_bits))); // R1

    AST_SCALL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd0 && op_imm == 5'd7)
        |=> (!ie_bits[0] && ie_bits[1] == $past(ie_bits[0]) && ie_bits[2] == $past(ie_bits[2])
             && save_we && save_reg == 5'd30 && save_data == $past(op_pc))); // R2

    AST_BREAK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd0 && op_imm == 5'd2)
        |=> (!ie_bits[0] && ie_bits[2] == $past(ie_bits[0]) && ie_bits[1] == $past(ie_bits[1])
             && save_we && save_reg == 5'd31)); // R3

    AST_EXC_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd2 && op_reg == 5'd30)
        |=> (ie_bits[0] == $past(ie_bits[1]) && ie_bits[2:1] == $past(ie_bits[2:1])
             && redirect_valid && redirect_pc == $past(op_target))); // R4

    AST_BRK_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd2 && op_reg == 5'd31)
        |=> (ie_bits[0] == $past(ie_bits[2]) && ie_bits[2:1] == $past(ie_bits[2:1])
             && redirect_valid && redirect_pc == $past(op_target))); // R5

    AST_DIVZ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd1 && op_divisor_zero)
        |=> (exc_valid && exc_code == 3'd5 && save_reg == 5'd30 && save_data == $past(op_pc))); // R6

    AST_VECTOR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (redirect_valid
                       && redirect_pc[BASE_LSB-1:0] == {exc_code, {VEC_SHIFT{1'b0}}})); // R7

    AST_ENTRY_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd0 && op_imm == 5'd7 && csr_we)
        |=> (!csr_err && !ie_bits[0])); // R11

endmodule

bind exc_ctl_unit exc_ctl_checker #(.XLEN(XLEN)) u_exc_ctl_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .op_valid        (op_valid),
    .op_kind         (op_kind),
    .op_imm          (op_imm),
    .op_reg          (op_reg),
    .op_divisor_zero (op_divisor_zero),
    .op_pc           (op_pc),
    .op_target       (op_target),
    .csr_we          (csr_we),
    .ie_bits         (ie_bits),
    .redirect_valid  (redirect_valid),
    .redirect_pc     (redirect_pc),
    .save_we         (save_we),
    .save_reg        (save_reg),
    .save_data       (save_data),
    .exc_valid       (exc_valid),
    .exc_code        (exc_code),
    .illegal_op      (illegal_op),
    .csr_err         (csr_err)
);

// File: tb/tb_exc_ctl_unit.sv
// Sweep bench for exc_ctl_unit at XLEN=16.
module tb_exc_ctl_unit;

    localparam int          CLK_PERIOD = 10;
    localparam int          W          = 16;
    localparam logic [15:0] BASE0      = 16'h1200;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          op_valid;
    logic [1:0]    op_kind;
    logic [W-1:0]  op_pc;
    logic [4:0]    op_imm;
    logic [4:0]    op_reg;
    logic          op_divisor_zero;
    logic [W-1:0]  op_target;
    logic          csr_we;
    logic          csr_re;
    logic [4:0]    csr_idx;
    logic [W-1:0]  csr_wdata;
    logic [W-1:0]  csr_pc;
    logic [2:0]    ie_bits;
    logic          redirect_valid;
    logic [W-1:0]  redirect_pc;
    logic          save_we;
    logic [4:0]    save_reg;
    logic [W-1:0]  save_data;
    logic          exc_valid;
    logic [2:0]    exc_code;
    logic          illegal_op;
    logic [W-1:0]  csr_rd_data;
    logic          csr_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [2:0]  m_en;
    logic [15:0] m_base;

    exc_ctl_unit #(.XLEN(W), .RESET_BASE(BASE0)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_pc(op_pc), .op_imm(op_imm), .op_reg(op_reg),
        .op_divisor_zero(op_divisor_zero), .op_target(op_target),
        .csr_we(csr_we), .csr_re(csr_re), .csr_idx(csr_idx),
        .csr_wdata(csr_wdata), .csr_pc(csr_pc), .ie_bits(ie_bits),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .save_we(save_we), .save_reg(save_reg), .save_data(save_data),
        .exc_valid(exc_valid), .exc_code(exc_code), .illegal_op(illegal_op),
        .csr_rd_data(csr_rd_data), .csr_err(csr_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        op_valid = 0; op_kind = 2'd3; op_pc = '0; op_imm = '0; op_reg = '0;
        op_divisor_zero = 0; op_target = '0;
        csr_we = 0; csr_re = 0; csr_idx = '0; csr_wdata = '0; csr_pc = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [15:0] vec(input logic [2:0] code);
        return {m_base[15:8], 8'h00} + 16'(32 * code);
    endfunction

    task automatic set_en(input logic [2:0] v, input logic [15:0] pc);
        csr_we = 1; csr_idx = 5'd0; csr_wdata = {13'h1ABC, v}; csr_pc = pc;
        step();
        check("R8 enable write value", 32'(ie_bits), 32'(v));
        check("R8 refetch valid", 32'(redirect_valid), 1);
        check("R8 refetch pc", 32'(redirect_pc), 32'(16'(pc + 16'd4)));
        m_en = v;
        idle_in();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle_in();
        rst_n = 0;
        m_en = 3'd0;
        m_base = BASE0;
        repeat (3) step();
        check("R12 reset enable", 32'(ie_bits), 0);
        check("R12 reset redirect", 32'(redirect_valid), 0);
        check("R12 reset save", 32'(save_we), 0);
        check("R12 reset exc", 32'(exc_valid), 0);
        check("R12 reset err", 32'(csr_err), 0);
        rst_n = 1;
        csr_re = 1; csr_idx = 5'd3;
        step();
        check("R12 reset base", 32'(csr_rd_data), 32'(BASE0));
        idle_in();

        // Trap immediates against every enable value.
        for (int imm = 0; imm < 32; imm++) begin
            for (int e = 0; e < 8; e++) begin
                logic [2:0]  ev;
                logic [15:0] pc;
                ev = 3'(e);
                pc = 16'h0400 + 16'(imm * 4);
                set_en(ev, 16'h0100);
                op_valid = 1; op_kind = 2'd0; op_imm = 5'(imm); op_pc = pc;
                step();
                if (imm == 7) begin
                    check("R2 scall enable", 32'(ie_bits), 32'({ev[2], ev[0], 1'b0}));
                    check("R2 scall link reg", 32'(save_reg), 30);
                    check("R2 scall link data", 32'(save_data), 32'(pc));
                    check("R7 scall code", 32'(exc_code), 7);
                    check("R7 scall vector", 32'(redirect_pc), 32'(vec(3'd7)));
                end else if (imm == 2) begin
                    check("R3 break enable", 32'(ie_bits), 32'({ev[0], ev[1], 1'b0}));
                    check("R3 break link reg", 32'(save_reg), 31);
                    check("R3 break link data", 32'(save_data), 32'(pc));
                    check("R7 break code", 32'(exc_code), 1);
                    check("R7 break vector", 32'(redirect_pc), 32'(vec(3'd1)));
                end else begin
                    check("R1 illegal pulse", 32'(illegal_op), 1);
                    check("R1 illegal enable kept", 32'(ie_bits), 32'(ev));
                    check("R1 illegal no redirect", 32'(redirect_valid), 0);
                    check("R1 illegal no save", 32'(save_we), 0);
                    check("R1 illegal no exc", 32'(exc_valid), 0);
                end
                idle_in();
            end
        end
        step();
        check("R12 pulse ends", 32'({redirect_valid, save_we, exc_valid, illegal_op}), 0);

        // Register jumps against every enable value.
        for (int r = 0; r < 32; r++) begin
            for (int e = 0; e < 8; e++) begin
                logic [2:0]  ev;
                logic [15:0] tgt;
                ev = 3'(e);
                tgt = 16'h3000 + 16'(r * 16 + e * 2);
                set_en(ev, 16'h0200);
                op_valid = 1; op_kind = 2'd2; op_reg = 5'(r); op_target = tgt;
                step();
                check("R4 jump redirect", 32'(redirect_valid), 1);
                check("R4 jump target", 32'(redirect_pc), 32'(tgt));
                if (r == 30)
                    check("R4 exc return enable", 32'(ie_bits), 32'({ev[2:1], ev[1]}));
                else if (r == 31)
                    check("R5 brk return enable", 32'(ie_bits), 32'({ev[2:1], ev[2]}));
                else
                    check("R4 plain jump enable kept", 32'(ie_bits), 32'(ev));
                idle_in();
            end
        end

        // Divide with zero and nonzero divisor.
        for (int z = 0; z < 2; z++) begin
            for (int e = 0; e < 8; e++) begin
                logic [2:0] ev;
                ev = 3'(e);
                set_en(ev, 16'h0300);
                op_valid = 1; op_kind = 2'd1; op_divisor_zero = z[0];
                op_pc = 16'h0800 + 16'(e * 4);
                step();
                if (z == 1) begin
                    check("R6 divz code", 32'(exc_code), 5);
                    check("R6 divz enable", 32'(ie_bits), 32'({ev[2], ev[0], 1'b0}));
                    check("R6 divz pc", 32'(save_data), 32'(16'h0800 + 16'(e * 4)));
                    check("R6 divz link reg", 32'(save_reg), 30);
                    check("R7 divz vector", 32'(redirect_pc), 32'(vec(3'd5)));
                end else begin
                    check("R6 div ok no exc", 32'(exc_valid), 0);
                    check("R6 div ok no redirect", 32'(redirect_valid), 0);
                    check("R6 div ok enable", 32'(ie_bits), 32'(ev));
                end
                idle_in();
            end
        end

        // Base rewrite, low bits ignored by the vector.
        csr_we = 1; csr_idx = 5'd3; csr_wdata = 16'hABCD; csr_pc = 16'h0500;
        step();
        check("R9 base write no redirect", 32'(redirect_valid), 0);
        check("R9 base write no err", 32'(csr_err), 0);
        m_base = 16'hABCD;
        idle_in();
        csr_re = 1; csr_idx = 5'd3;
        step();
        check("R9 base read", 32'(csr_rd_data), 32'hABCD);
        idle_in();
        op_valid = 1; op_kind = 2'd0; op_imm = 5'd7; op_pc = 16'h0600;
        step();
        check("R7 vector from new base", 32'(redirect_pc), 32'h0000ABE0);
        m_en = {m_en[2], m_en[0], 1'b0};
        idle_in();

        // Write sweep over every index.
        for (int i = 0; i < 32; i++) begin
            logic legal;
            legal = (i <= 3) || (i >= 6 && i <= 15);
            set_en(3'd1, 16'h0700);
            csr_we = 1; csr_idx = 5'(i); csr_wdata = 16'h5506; csr_pc = 16'h0900;
            step();
            check("R10 write error", 32'(csr_err), 32'(!legal));
            check("R8 write refetch", 32'(redirect_valid), 32'(i <= 2));
            if (i <= 2) check("R8 write refetch pc", 32'(redirect_pc), 32'h0904);
            check("R8 write enable", 32'(ie_bits), (i == 0) ? 32'd6 : 32'd1);
            if (i == 3) m_base = 16'h5506;
            idle_in();
        end
        // Read sweep over every index.
        set_en(3'd5, 16'h0a00);
        for (int i = 0; i < 32; i++) begin
            logic [15:0] expd;
            csr_re = 1; csr_idx = 5'(i);
            step();
            expd = (i == 0) ? 16'h0005 : (i == 3) ? m_base : 16'h0000;
            check("R10 read error", 32'(csr_err), 32'(i > 5));
            check("R9 read data", 32'(csr_rd_data), 32'(expd));
            idle_in();
        end

        // Collisions between operations and software writes.
        set_en(3'd7, 16'h0b00);
        op_valid = 1; op_kind = 2'd0; op_imm = 5'd7; op_pc = 16'h0c00;
        csr_we = 1; csr_idx = 5'd0; csr_wdata = 16'h0000; csr_pc = 16'h0d00;
        step();
        check("R11 entry wins enable", 32'(ie_bits), 32'd6);
        check("R11 entry wins redirect", 32'(redirect_pc), 32'(vec(3'd7)));
        check("R11 entry wins no err", 32'(csr_err), 0);
        idle_in();
        op_valid = 1; op_kind = 2'd2; op_reg = 5'd5; op_target = 16'h4444;
        csr_we = 1; csr_idx = 5'd4; csr_pc = 16'h0d00;
        step();
        check("R11 jump drops bad write err", 32'(csr_err), 0);
        check("R11 jump wins redirect", 32'(redirect_pc), 32'h4444);
        idle_in();
        op_valid = 1; op_kind = 2'd2; op_reg = 5'd7; op_target = 16'h5550;
        csr_we = 1; csr_idx = 5'd0; csr_wdata = 16'h0001; csr_pc = 16'h0d00;
        step();
        check("R11 jump drops enable write", 32'(ie_bits), 32'd6);
        idle_in();
        op_valid = 1; op_kind = 2'd0; op_imm = 5'd9;
        csr_we = 1; csr_idx = 5'd0; csr_wdata = 16'h0003; csr_pc = 16'h0e00;
        step();
        check("R11 illegal trap keeps write", 32'(ie_bits), 32'd3);
        check("R1 illegal with write pulse", 32'(illegal_op), 1);
        idle_in();
        step();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule